// File: doc/BRIEF.md
# Unary Codec: Thermometer Encoder and Grouped Bit-Count Decoder

This block provides the two converters that surround a logic-gate network working in unary form. On the way in, an unsigned 8-bit sample becomes a 255-bit thermometer code. The number of set bits equals the sample, and the set bits always fill the low end of the vector. On the way out, the network's wide result vector is cut into a fixed number of equal, contiguous groups. Each group's set bits are counted, and the counts are returned as binary integers.

The two converters are independent. Each has its own valid/ready handshake at its input and at its output, so it can stall and accept new data at the same pace as its neighbours. The encoder has a single register stage. The decoder counts through an adder tree split over two register stages. It can also divide every group count by a power of two, set by a parameter, to rescale the result. The group count, the group width and the shift are parameters. An output width that does not divide evenly into the groups is refused when the design is elaborated.

Top module: `unary_codec`

## Requirements
- R1: For an accepted encoder input v, bit i of the 255-bit code (bit 0 is the LSB) is 1 exactly when i < v. So v = 0 yields all zeros and v = 255 yields all ones.
- R2: The encoder output becomes valid after the rising edge that accepts the input. It is consumed on an edge where output ready is high.
- R3: While the encoder output is valid and output ready is low, the code and the valid flag hold, input ready is low, and no value is lost.
- R4: The decoder splits its 256-bit input into 4 groups of 64 bits. Group g is bits [64g+63:64g]. Output field g, dec_out_sums[7g+6:7g], is the number of set bits in group g.
- R5: Each field equals the group count shifted right by the SUM_SHIFT parameter, with truncation (default 0).
- R6: A decoder result is valid after the second rising edge, counting the edge that accepts the input. It is not valid after the first.
- R7: With output ready held high, the decoder accepts one vector per cycle and delivers results in order. While output ready is low, the result holds, one further vector may enter, and input ready then drops.
- R8: During reset, both output valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encoder input valid |
| enc_in_ready | output | 1 | Encoder can accept |
| enc_in_value | input | VAL_W | Unsigned sample to encode |
| enc_out_valid | output | 1 | Thermometer code valid |
| enc_out_ready | input | 1 | Downstream takes the code |
| enc_out_therm | output | 2**VAL_W-1 | Thermometer code |
| dec_in_valid | input | 1 | Decoder input valid |
| dec_in_ready | output | 1 | Decoder can accept |
| dec_in_bits | input | NET_W | Network output bits |
| dec_out_valid | output | 1 | Group counts valid |
| dec_out_ready | input | 1 | Downstream takes the counts |
| dec_out_sums | output | N_GRP*SUM_W | Packed group counts, group 0 in the LSBs |

## Verification
The assertions assume that a source holding valid high keeps its data unchanged until that data is accepted, and that reset is held for at least one clock edge. The stall and hold checks rest on both assumptions. The bench changes input data only at falling edges. It lowers valid, or presents the next item, only after the accepting edge has passed. Because of this, every stall scenario keeps the input stable while it waits.

// File: rtl/unary_codec_pkg.sv
package unary_codec_pkg;

  // Width needed to hold a count from 0 to n inclusive.
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // A level v sets code position i when the position lies below the level.
  function automatic logic level_bit(input int unsigned v, input int unsigned i);
    return i < v;
  endfunction

  // Rescaling of a group count: truncating division by 2**sh.
  function automatic int unsigned rescale(input int unsigned s, input int unsigned sh);
    return s >> sh;
  endfunction

endpackage

// File: rtl/therm_encoder.sv
module therm_encoder
  import unary_codec_pkg::*;
#(
  parameter int VAL_W   = 8,
  parameter int THERM_W = (1 << VAL_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VAL_W-1:0]   in_value,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [THERM_W-1:0] out_therm
);

  logic               in_fire;
  logic               slot_free;
  logic [THERM_W-1:0] therm_d;
  logic [THERM_W-1:0] therm_q;
  logic               valid_q;

  assign slot_free = !valid_q || out_ready;
  assign in_ready  = slot_free;
  assign in_fire   = in_valid && slot_free;

  always_comb begin
    for (int i = 0; i < THERM_W; i++) begin
      therm_d[i] = level_bit(int'(in_value), i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      therm_q <= '0;
    end else if (slot_free) begin
      valid_q <= in_valid;
      if (in_valid) therm_q <= therm_d;
    end
  end

  assign out_valid = valid_q;
  assign out_therm = therm_q;

  // R1
  therm_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (((therm_q >> 1) & ~therm_q) == '0));

  // R1
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> ($countones(therm_q) == int'($past(in_value))));

  // R3
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(therm_q)));

  // R3
  enc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |-> !in_ready);

endmodule

// File: rtl/group_adder.sv
module group_adder
  import unary_codec_pkg::*;
#(
  parameter int GRP_W     = 64,
  parameter int N_PART    = 4,
  parameter int SUM_SHIFT = 0,
  parameter int SUM_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_load,
  input  logic             s2_load,
  input  logic [GRP_W-1:0] bits,
  output logic [SUM_W-1:0] sum
);

  localparam int PART_W = GRP_W / N_PART;
  localparam int PSUM_W = count_width(PART_W);

  logic [PSUM_W-1:0] part_d [N_PART];
  logic [PSUM_W-1:0] part_q [N_PART];
  logic [SUM_W-1:0]  total;
  logic [SUM_W-1:0]  sum_d;
  logic [SUM_W-1:0]  sum_q;

  // Stage 1: one count per slice of the group.
  always_comb begin
    for (int p = 0; p < N_PART; p++) begin
      part_d[p] = '0;
      for (int b = 0; b < PART_W; b++) begin
        part_d[p] = part_d[p] + PSUM_W'(bits[p*PART_W + b]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PART; p++) part_q[p] <= '0;
    end else if (s1_load) begin
      for (int p = 0; p < N_PART; p++) part_q[p] <= part_d[p];
    end
  end

  // Stage 2: add the slice counts, then rescale.
  always_comb begin
    total = '0;
    for (int p = 0; p < N_PART; p++) begin
      total = total + SUM_W'(part_q[p]);
    end
    sum_d = SUM_W'(rescale(int'(total), SUM_SHIFT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sum_q <= '0;
    else if (s2_load) sum_q <= sum_d;
  end

  assign sum = sum_q;

  // R5
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_q) <= (GRP_W >> SUM_SHIFT));

endmodule

// File: rtl/group_sum_decoder.sv
module group_sum_decoder
  import unary_codec_pkg::*;
#(
  parameter int NET_W     = 256,
  parameter int N_GRP     = 4,
  parameter int N_PART    = 4,
  parameter int SUM_SHIFT = 0,
  parameter int GRP_W     = NET_W / N_GRP,
  parameter int SUM_W     = $clog2(GRP_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NET_W-1:0]       in_bits,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [N_GRP*SUM_W-1:0] out_sums
);

  if (NET_W % N_GRP != 0) begin : g_bad_groups
    $error("group_sum_decoder: NET_W must be a multiple of N_GRP");
  end
  if (GRP_W % N_PART != 0) begin : g_bad_parts
    $error("group_sum_decoder: group width must be a multiple of N_PART");
  end

  logic s1_valid;
  logic s2_valid;
  logic adv1;
  logic adv2;
  logic in_fire;

  assign adv2     = !s2_valid || out_ready;
  assign adv1     = !s1_valid || adv2;
  assign in_ready = adv1;
  assign in_fire  = in_valid && adv1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      if (adv1) s1_valid <= in_valid;
      if (adv2) s2_valid <= s1_valid;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    group_adder #(
      .GRP_W(GRP_W), .N_PART(N_PART), .SUM_SHIFT(SUM_SHIFT), .SUM_W(SUM_W)
    ) u_add (
      .clk(clk),
      .rst_n(rst_n),
      .s1_load(in_fire),
      .s2_load(adv2 && s1_valid),
      .bits(in_bits[g*GRP_W +: GRP_W]),
      .sum(out_sums[g*SUM_W +: SUM_W])
    );
  end

  assign out_valid = s2_valid;

  // R6
  dec_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> s1_valid);

  // R6
  dec_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && adv2) |=> s2_valid);

  // R7
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !out_ready) |=> (s2_valid && $stable(out_sums)));

  // R7
  dec_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s2_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/unary_codec.sv
module unary_codec #(
  parameter int VAL_W     = 8,
  parameter int NET_W     = 256,
  parameter int N_GRP     = 4,
  parameter int N_PART    = 4,
  parameter int SUM_SHIFT = 0,
  localparam int THERM_W  = (1 << VAL_W) - 1,
  localparam int GRP_W    = NET_W / N_GRP,
  localparam int SUM_W    = $clog2(GRP_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enc_in_valid,
  output logic                   enc_in_ready,
  input  logic [VAL_W-1:0]       enc_in_value,
  output logic                   enc_out_valid,
  input  logic                   enc_out_ready,
  output logic [THERM_W-1:0]     enc_out_therm,
  input  logic                   dec_in_valid,
  output logic                   dec_in_ready,
  input  logic [NET_W-1:0]       dec_in_bits,
  output logic                   dec_out_valid,
  input  logic                   dec_out_ready,
  output logic [N_GRP*SUM_W-1:0] dec_out_sums
);

  therm_encoder #(.VAL_W(VAL_W), .THERM_W(THERM_W)) u_enc (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(enc_in_valid),
    .in_ready(enc_in_ready),
    .in_value(enc_in_value),
    .out_valid(enc_out_valid),
    .out_ready(enc_out_ready),
    .out_therm(enc_out_therm)
  );

  group_sum_decoder #(
    .NET_W(NET_W), .N_GRP(N_GRP), .N_PART(N_PART), .SUM_SHIFT(SUM_SHIFT),
    .GRP_W(GRP_W), .SUM_W(SUM_W)
  ) u_dec (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(dec_in_valid),
    .in_ready(dec_in_ready),
    .in_bits(dec_in_bits),
    .out_valid(dec_out_valid),
    .out_ready(dec_out_ready),
    .out_sums(dec_out_sums)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!enc_out_valid && !dec_out_valid));

endmodule

// File: tb/unary_codec_tb.sv
module unary_codec_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [7:0]   enc_in_value;
  logic [254:0] enc_out_therm;
  logic         dec_in_valid, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [255:0] dec_in_bits;
  logic [27:0]  dec_out_sums;
  logic         s_enc_in_ready, s_enc_out_valid, s_dec_in_ready, s_dec_out_valid;
  logic [254:0] s_enc_out_therm;
  logic [27:0]  s_dec_out_sums;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  unary_codec u_dut (
    .clk, .rst_n, .enc_in_valid, .enc_in_ready, .enc_in_value,
    .enc_out_valid, .enc_out_ready, .enc_out_therm,
    .dec_in_valid, .dec_in_ready, .dec_in_bits,
    .dec_out_valid, .dec_out_ready, .dec_out_sums
  );

  unary_codec #(.SUM_SHIFT(2)) u_dut_shift (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(s_enc_in_ready),
    .enc_in_value(enc_in_value), .enc_out_valid(s_enc_out_valid),
    .enc_out_ready(enc_out_ready), .enc_out_therm(s_enc_out_therm),
    .dec_in_valid(dec_in_valid), .dec_in_ready(s_dec_in_ready),
    .dec_in_bits(dec_in_bits), .dec_out_valid(s_dec_out_valid),
    .dec_out_ready(dec_out_ready), .dec_out_sums(s_dec_out_sums)
  );

  function automatic logic [254:0] exp_therm(input int v);
    logic [254:0] r = '0;
    for (int k = 0; k < v; k++) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic [27:0] exp_sums(input logic [255:0] vec, input int sh);
    logic [27:0] r = '0;
    for (int g = 0; g < 4; g++) begin
      int c = 0;
      for (int b = 0; b < 64; b++) if (vec[g*64 + b]) c++;
      c = c / (1 << sh);
      r[g*7 +: 7] = 7'(c);
    end
    return r;
  endfunction

  function automatic logic [255:0] rand_vec();
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic enc_one(input int v);
    @(negedge clk);
    enc_in_valid = 1'b1; enc_in_value = 8'(v); enc_out_ready = 1'b1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk(enc_out_valid == 1'b1, "R2", "encoder valid after one edge", 256'(enc_out_valid), 256'(1));
    chk(enc_out_therm == exp_therm(v), "R1", "thermometer code", 256'(enc_out_therm), 256'(exp_therm(v)));
  endtask

  task automatic dec_check(input logic [255:0] vec, input string req);
    chk(dec_out_valid == 1'b1, req, "decoder valid", 256'(dec_out_valid), 256'(1));
    chk(dec_out_sums == exp_sums(vec, 0), "R4", "group counts", 256'(dec_out_sums), 256'(exp_sums(vec, 0)));
    chk(s_dec_out_sums == exp_sums(vec, 2), "R5", "shifted counts", 256'(s_dec_out_sums), 256'(exp_sums(vec, 2)));
  endtask

  task automatic dec_one(input logic [255:0] vec);
    @(negedge clk);
    dec_in_valid = 1'b1; dec_in_bits = vec; dec_out_ready = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk(dec_out_valid == 1'b0, "R6", "not valid after first edge", 256'(dec_out_valid), 256'(0));
    @(negedge clk);
    dec_check(vec, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] vecs [6];
    logic [255:0] va, vb;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    enc_in_valid = 1'b0; enc_in_value = '0; enc_out_ready = 1'b1;
    dec_in_valid = 1'b0; dec_in_bits = '0;  dec_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R8: outputs quiet during reset
    chk(enc_out_valid == 1'b0, "R8", "encoder valid in reset", 256'(enc_out_valid), 256'(0));
    chk(dec_out_valid == 1'b0, "R8", "decoder valid in reset", 256'(dec_out_valid), 256'(0));
    rst_n = 1'b1;

    // R1 corners then random levels
    enc_one(0); enc_one(255); enc_one(1); enc_one(254); enc_one(128);
    for (int k = 0; k < 20; k++) enc_one(int'($urandom % 256));

    // R3: stall the encoder output
    @(negedge clk);
    enc_out_ready = 1'b0; enc_in_valid = 1'b1; enc_in_value = 8'd77;
    @(negedge clk);
    enc_in_value = 8'd200;
    chk(enc_in_ready == 1'b0, "R3", "input ready low when full", 256'(enc_in_ready), 256'(0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(enc_out_valid && enc_out_therm == exp_therm(77), "R3", "held code",
          256'(enc_out_therm), 256'(exp_therm(77)));
    end
    enc_out_ready = 1'b1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk(enc_out_valid && enc_out_therm == exp_therm(200), "R3", "next code after release",
        256'(enc_out_therm), 256'(exp_therm(200)));
    @(negedge clk);
    chk(enc_out_valid == 1'b0, "R3", "drained", 256'(enc_out_valid), 256'(0));

    // R4 / R5 / R6: directed and random vectors
    dec_one('0);
    dec_one('1);
    dec_one({64{4'b1010}});
    dec_one({192'd0, {64{1'b1}}});
    dec_one({{63{1'b0}}, 1'b1, 192'd3});
    for (int k = 0; k < 20; k++) dec_one(rand_vec());

    // R7: back-to-back stream
    for (int k = 0; k < 6; k++) vecs[k] = rand_vec();
    dec_out_ready = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 2) dec_check(vecs[c-2], "R7");
      if (c < 6) begin
        chk(dec_in_ready == 1'b1, "R7", "ready while streaming", 256'(dec_in_ready), 256'(1));
        dec_in_valid = 1'b1; dec_in_bits = vecs[c];
      end else begin
        dec_in_valid = 1'b0;
      end
    end

    // R7: output stall with one more vector entering
    va = rand_vec(); vb = rand_vec();
    @(negedge clk);
    dec_out_ready = 1'b0; dec_in_valid = 1'b1; dec_in_bits = va;
    @(negedge clk);
    dec_in_valid = 1'b0;
    @(negedge clk);
    dec_check(va, "R7");
    dec_in_valid = 1'b1; dec_in_bits = vb;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk(dec_in_ready == 1'b0, "R7", "input ready low when both stages full",
        256'(dec_in_ready), 256'(0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      dec_check(va, "R7");
    end
    dec_out_ready = 1'b1;
    @(negedge clk);
    dec_check(vb, "R7");
    @(negedge clk);
    chk(dec_out_valid == 1'b0, "R7", "decoder drained", 256'(dec_out_valid), 256'(0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule